// File: doc/BRIEF.md
# Secure Memory Region Access Filter

This block sits in front of a memory port and decides, for every transaction, whether it may proceed. Each transaction carries a 48-bit address, a direction (read or write) and a security state (secure or non-secure). The filter holds up to eight address windows. Each window has an inclusive lower and upper bound at 64 KiB granularity and four permission bits, one for each combination of security state and direction. One cycle after a request, the filter reports allow or deny.

Software programs the windows over a plain 32-bit register bus. Writes land in a staging copy of the window table that has no effect on decisions. A two-step command then moves the whole staging copy into the active copy in a single cycle. The first step arms the transfer and the second performs it. A status field shows whether a transfer has happened since reset. A fixed identification word allows software to confirm that the block is present.

Top module: `sec_region_filter`

## Requirements
- R1: After reset the status word (offset 0x00) reads 0, every staging register reads 0, and every transaction is denied.
- R2: Window n owns four words starting at 0x80 + 16*n: +0x0 lower-bound address bits 31:16 (in data bits 31:16) with the permission bits in data bits 3:0; +0x4 lower-bound address bits 47:32 (in data bits 15:0); +0x8 upper-bound address bits 31:16 (in data bits 31:16); +0xC upper-bound address bits 47:32 (in data bits 15:0). All other data bits are dropped on write and read back as 0.
- R3: The word at offset 0x1FE0 always reads 0x54, and writes to it have no effect.
- R4: Writes to staging registers do not change any decision until a transfer is performed.
- R5: Writing 3 to the command register (offset 0x08) and then writing 4 copies all staging windows into the active set at once. Afterwards status bits 2:0 read 3.
- R6: A write of 4 performs nothing unless the preceding command write was 3. Any other command value cancels a pending 3.
- R7: A window matches when address bits 47:16 lie between the lower and upper bound inclusive. This means the upper bound covers its whole 64 KiB block.
- R8: Permission bit 0 allows non-secure reads, bit 1 non-secure writes, bit 2 secure reads and bit 3 secure writes.
- R9: A window counts as enabled when at least one of its permission bits is set. When several enabled windows match, the highest-numbered one decides. Matching windows with no permission bits set are skipped.
- R10: A transaction that matches no enabled window is denied.
- R11: `resp_valid` is high exactly one cycle after `txn_valid`. `resp_allow` is never high without `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| txn_valid | input | 1 | Transaction request |
| txn_addr | input | 48 | Transaction address |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_secure | input | 1 | 1 = secure, 0 = non-secure |
| resp_valid | output | 1 | Decision available (one cycle after request) |
| resp_allow | output | 1 | 1 = allowed, 0 = denied |

## Verification
The bench builds the filter with its default parameters: eight windows, a 48-bit address and 64 KiB granularity. This makes the full 16-bit upper address word and the top window at offset 0xF0 reachable. The default granularity also places the bound fields next to the permission bits in the same word. With these values the bench can stack three overlapping windows, so priority and the skipping of windows without permissions are both exercised. It can also place a probe address in the upper half of the 48-bit space, where only a window reaching bit 47 can match.

// File: rtl/srf_pkg.sv
package srf_pkg;

    // command codes written to the command word
    localparam logic [31:0] CMD_ARM    = 32'd3;
    localparam logic [31:0] CMD_COMMIT = 32'd4;

    // status field values
    localparam logic [2:0] STS_RESET = 3'd0;
    localparam logic [2:0] STS_LIVE  = 3'd3;

    // fixed register offsets
    localparam logic [12:0] OFS_STATUS = 13'h0000;
    localparam logic [12:0] OFS_CMD    = 13'h0008;
    localparam logic [12:0] OFS_IDENT  = 13'h1FE0;
    localparam logic [31:0] IDENT_WORD = 32'h0000_0054;

    // window register window
    localparam int unsigned WIN_BASE   = 32'h80;
    localparam int unsigned WIN_STRIDE = 16;

    // word inside a window block, selected by offset bits 3:2
    typedef enum logic [1:0] {
        WD_LO_LOW  = 2'd0,
        WD_LO_HIGH = 2'd1,
        WD_HI_LOW  = 2'd2,
        WD_HI_HIGH = 2'd3
    } win_word_e;

    // permission bit index = {secure, write}
    typedef enum logic [1:0] {
        PB_NS_RD = 2'd0,
        PB_NS_WR = 2'd1,
        PB_S_RD  = 2'd2,
        PB_S_WR  = 2'd3
    } perm_bit_e;

endpackage

// File: rtl/srf_regfile.sv
module srf_regfile
    import srf_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 8,
    parameter int unsigned ADDR_W      = 48,
    parameter int unsigned GRAN_BITS   = 16,
    parameter int unsigned RAW         = 13,
    localparam int unsigned BW         = ADDR_W - GRAN_BITS,
    localparam int unsigned LOW_KEEP   = 32 - GRAN_BITS,
    localparam int unsigned HIGH_KEEP  = ADDR_W - 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [RAW-1:0]                   addr,
    input  logic [31:0]                      wdata,
    output logic [31:0]                      rdata,
    output logic [NUM_REGIONS-1:0][BW-1:0]   act_lo,
    output logic [NUM_REGIONS-1:0][BW-1:0]   act_hi,
    output logic [NUM_REGIONS-1:0][3:0]      act_perm
);

    localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
    localparam int unsigned SPAN  = NUM_REGIONS * WIN_STRIDE;

    typedef struct packed {
        logic [NUM_REGIONS-1:0][BW-1:0] stg_lo;
        logic [NUM_REGIONS-1:0][BW-1:0] stg_hi;
        logic [NUM_REGIONS-1:0][3:0]    stg_perm;
        logic [NUM_REGIONS-1:0][BW-1:0] act_lo;
        logic [NUM_REGIONS-1:0][BW-1:0] act_hi;
        logic [NUM_REGIONS-1:0][3:0]    act_perm;
        logic                           armed;
        logic [2:0]                     status;
    } rf_state_t;

    rf_state_t state_d, state_q;

    // address decode shared by the write and read paths
    logic [RAW-1:0]   rel_addr;
    logic             in_win;
    logic [IDX_W-1:0] win_idx;
    win_word_e        win_word;

    always_comb begin
        rel_addr = addr - RAW'(WIN_BASE);
        in_win   = (addr >= RAW'(WIN_BASE)) && (addr < RAW'(WIN_BASE + SPAN));
        win_idx  = rel_addr[4 +: IDX_W];
        win_word = win_word_e'(rel_addr[3:2]);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (addr == RAW'(OFS_CMD)) begin
                if (wdata == CMD_ARM) begin
                    state_d.armed = 1'b1;
                end else if (wdata == CMD_COMMIT && state_q.armed) begin
                    state_d.act_lo   = state_q.stg_lo;
                    state_d.act_hi   = state_q.stg_hi;
                    state_d.act_perm = state_q.stg_perm;
                    state_d.status   = STS_LIVE;
                    state_d.armed    = 1'b0;
                end else begin
                    state_d.armed = 1'b0;
                end
            end else if (in_win) begin
                unique case (win_word)
                    WD_LO_LOW: begin
                        state_d.stg_lo[win_idx][LOW_KEEP-1:0] = wdata[31:GRAN_BITS];
                        state_d.stg_perm[win_idx]             = wdata[3:0];
                    end
                    WD_LO_HIGH: state_d.stg_lo[win_idx][BW-1:LOW_KEEP] = wdata[HIGH_KEEP-1:0];
                    WD_HI_LOW:  state_d.stg_hi[win_idx][LOW_KEEP-1:0]  = wdata[31:GRAN_BITS];
                    WD_HI_HIGH: state_d.stg_hi[win_idx][BW-1:LOW_KEEP] = wdata[HIGH_KEEP-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // read path
    always_comb begin
        rdata = '0;
        if (addr == RAW'(OFS_STATUS)) begin
            rdata[2:0] = state_q.status;
        end else if (addr == RAW'(OFS_IDENT)) begin
            rdata = IDENT_WORD;
        end else if (in_win) begin
            unique case (win_word)
                WD_LO_LOW: begin
                    rdata[31:GRAN_BITS] = state_q.stg_lo[win_idx][LOW_KEEP-1:0];
                    rdata[3:0]          = state_q.stg_perm[win_idx];
                end
                WD_LO_HIGH: rdata[HIGH_KEEP-1:0]  = state_q.stg_lo[win_idx][BW-1:LOW_KEEP];
                WD_HI_LOW:  rdata[31:GRAN_BITS]   = state_q.stg_hi[win_idx][LOW_KEEP-1:0];
                WD_HI_HIGH: rdata[HIGH_KEEP-1:0]  = state_q.stg_hi[win_idx][BW-1:LOW_KEEP];
                default: ;
            endcase
        end
    end

    assign act_lo   = state_q.act_lo;
    assign act_hi   = state_q.act_hi;
    assign act_perm = state_q.act_perm;

    // R5: status only ever shows the reset or the live code
    assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.status == STS_RESET) || (state_q.status == STS_LIVE));

    // R4 / R6: the active set moves only when a transfer was armed
    assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(state_q.act_lo) || !$stable(state_q.act_hi) || !$stable(state_q.act_perm))
        |-> $past(state_q.armed));

    // R5: a transfer always leaves the block disarmed and live
    assert_commit_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.armed && wr_en && addr == RAW'(OFS_CMD) && wdata == CMD_COMMIT)
        |=> (!state_q.armed && state_q.status == STS_LIVE));

endmodule

// File: rtl/srf_region_match.sv
module srf_region_match #(
    parameter int unsigned NUM_REGIONS = 8,
    parameter int unsigned BW          = 32
) (
    input  logic [BW-1:0]                  key,
    input  logic [NUM_REGIONS-1:0][BW-1:0] lo,
    input  logic [NUM_REGIONS-1:0][BW-1:0] hi,
    input  logic [NUM_REGIONS-1:0][3:0]    perm,
    output logic [NUM_REGIONS-1:0]         hit
);

    // one comparator pair per window; a window with no permission is off
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        logic above_lo, below_hi, enabled;
        always_comb begin
            above_lo = key >= lo[g];
            below_hi = key <= hi[g];
            enabled  = |perm[g];
            hit[g]   = above_lo && below_hi && enabled;
        end
    end

endmodule

// File: rtl/srf_decide.sv
module srf_decide #(
    parameter int unsigned NUM_REGIONS = 8,
    localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          txn_valid,
    input  logic                          txn_write,
    input  logic                          txn_secure,
    input  logic [NUM_REGIONS-1:0]        hit,
    input  logic [NUM_REGIONS-1:0][3:0]   perm,
    output logic                          resp_valid,
    output logic                          resp_allow
);

    typedef struct packed {
        logic valid;
        logic allow;
    } dec_state_t;

    dec_state_t state_d, state_q;
    logic [IDX_W-1:0] winner;
    logic             any_hit;
    logic [1:0]       pbit;

    always_comb begin
        winner  = '0;
        any_hit = |hit;
        // ascending scan: the last set bit, i.e. the highest window, wins
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i]) winner = IDX_W'(i);
        end
        pbit = {txn_secure, txn_write};
        state_d.valid = txn_valid;
        state_d.allow = txn_valid && any_hit && perm[winner][pbit];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign resp_valid = state_q.valid;
    assign resp_allow = state_q.allow;

    assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> resp_valid);

    assert_resp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !resp_valid);

    assert_allow_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_allow |-> resp_valid);

    assert_nomatch_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && hit == '0) |=> !resp_allow);

endmodule

// File: rtl/sec_region_filter.sv
module sec_region_filter
    import srf_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 8,
    parameter int unsigned ADDR_W      = 48,
    parameter int unsigned GRAN_BITS   = 16,
    parameter int unsigned RAW         = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              txn_write,
    input  logic              txn_secure,
    output logic              resp_valid,
    output logic              resp_allow
);

    localparam int unsigned BW = ADDR_W - GRAN_BITS;

    logic [NUM_REGIONS-1:0][BW-1:0] act_lo, act_hi;
    logic [NUM_REGIONS-1:0][3:0]    act_perm;
    logic [NUM_REGIONS-1:0]         hit;
    logic [BW-1:0]                  key;

    assign key = txn_addr[ADDR_W-1:GRAN_BITS];

    srf_regfile #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .GRAN_BITS   (GRAN_BITS),
        .RAW         (RAW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .act_lo   (act_lo),
        .act_hi   (act_hi),
        .act_perm (act_perm)
    );

    srf_region_match #(
        .NUM_REGIONS (NUM_REGIONS),
        .BW          (BW)
    ) u_match (
        .key  (key),
        .lo   (act_lo),
        .hi   (act_hi),
        .perm (act_perm),
        .hit  (hit)
    );

    srf_decide #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_valid  (txn_valid),
        .txn_write  (txn_write),
        .txn_secure (txn_secure),
        .hit        (hit),
        .perm       (act_perm),
        .resp_valid (resp_valid),
        .resp_allow (resp_allow)
    );

endmodule

// File: tb/sim_sec_region_filter.sv
module sim_sec_region_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        txn_valid = 1'b0;
    logic [47:0] txn_addr = '0;
    logic        txn_write = 1'b0;
    logic        txn_secure = 1'b0;
    logic        resp_valid, resp_allow;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sec_region_filter u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_write(txn_write), .txn_secure(txn_secure),
        .resp_valid(resp_valid), .resp_allow(resp_allow)
    );

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [12:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_vec++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: read 0x%h got 0x%h expected 0x%h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_txn(input logic [47:0] a, input logic w, input logic s,
                           input logic exp, input string req);
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = a; txn_write = w; txn_secure = s;
        @(negedge clk);
        txn_valid = 1'b0;
        n_vec++;
        if (resp_valid !== 1'b1 || resp_allow !== exp) begin
            n_bad++;
            $display("FAIL %s: addr 0x%h w=%0b s=%0b got valid=%0b allow=%0b expected valid=1 allow=%0b",
                     req, a, w, s, resp_valid, resp_allow, exp);
        end
    endtask

    task automatic set_region(input int n, input logic [47:0] lo, input logic [47:0] hi,
                              input logic [3:0] perm);
        logic [12:0] b;
        b = 13'(32'h80 + n * 16);
        wr(b,        {lo[31:16], 12'h000, perm});
        wr(b + 13'h4, {16'h0, lo[47:32]});
        wr(b + 13'h8, hi[31:0]);
        wr(b + 13'hC, {16'h0, hi[47:32]});
    endtask

    task automatic commit();
        wr(13'h008, 32'd3);
        wr(13'h008, 32'd4);
    endtask

    task automatic t_reset();
        chk_rd(13'h000, 32'h0, "R1 status after reset");
        chk_rd(13'h080, 32'h0, "R1 staging after reset");
        chk_rd(13'h0FC, 32'h0, "R1 staging after reset");
        chk_txn(48'h0, 1'b0, 1'b0, 1'b0, "R1 deny after reset");
        chk_txn(48'h8000_0000_0000, 1'b1, 1'b1, 1'b0, "R1 deny after reset");
    endtask

    task automatic t_ident();
        chk_rd(13'h1FE0, 32'h54, "R3 ident");
        wr(13'h1FE0, 32'h0);
        chk_rd(13'h1FE0, 32'h54, "R3 ident after write");
    endtask

    task automatic t_layout();
        wr(13'h0A0, 32'hFFFF_FFFF);
        wr(13'h0A4, 32'hFFFF_FFFF);
        wr(13'h0A8, 32'hFFFF_FFFF);
        wr(13'h0AC, 32'hFFFF_FFFF);
        chk_rd(13'h0A0, 32'hFFFF_000F, "R2 lo low word");
        chk_rd(13'h0A4, 32'h0000_FFFF, "R2 lo high word");
        chk_rd(13'h0A8, 32'hFFFF_0000, "R2 hi low word");
        chk_rd(13'h0AC, 32'h0000_FFFF, "R2 hi high word");
        chk_rd(13'h090, 32'h0, "R2 neighbour untouched");
        wr(13'h0F0, 32'h0005_0003);
        chk_rd(13'h0F0, 32'h0005_0003, "R2 top window");
        set_region(2, 48'h0, 48'h0, 4'h0);
        set_region(7, 48'h0, 48'h0, 4'h0);
        chk_rd(13'h0A0, 32'h0, "R2 cleared");
    endtask

    task automatic t_commit();
        set_region(1, 48'h0000_1234_0000, 48'h0000_1235_ABCD, 4'h1);
        chk_txn(48'h0000_1234_0000, 1'b0, 1'b0, 1'b0, "R4 staged only");
        chk_rd(13'h000, 32'h0, "R4 status before transfer");
        commit();
        chk_rd(13'h000, 32'h3, "R5 status live");
        chk_txn(48'h0000_1234_0000, 1'b0, 1'b0, 1'b1, "R5 allowed after transfer");
        chk_txn(48'h0000_1235_FFFF, 1'b0, 1'b0, 1'b1, "R7 upper block end");
        chk_txn(48'h0000_1236_0000, 1'b0, 1'b0, 1'b0, "R7 above upper");
        chk_txn(48'h0000_1233_FFFF, 1'b0, 1'b0, 1'b0, "R7 below lower");
        chk_txn(48'h0001_1234_0000, 1'b0, 1'b0, 1'b0, "R7 high word differs");
        chk_txn(48'h0000_1234_8000, 1'b1, 1'b0, 1'b0, "R8 write not granted");
    endtask

    task automatic t_perms();
        for (int p = 0; p < 4; p++) begin
            logic [3:0] pm;
            pm = 4'(1 << p);
            set_region(3, 48'h0, 48'hFFFF_FFFF_FFFF, pm);
            commit();
            for (int k = 0; k < 4; k++) begin
                logic [1:0] kk;
                kk = 2'(k);
                chk_txn(48'h8000_0000_0000, kk[0], kk[1], pm[k], "R8 permission bit");
            end
        end
    endtask

    task automatic t_overlap();
        set_region(3, 48'h0, 48'hFFFF_FFFF_FFFF, 4'hF);
        set_region(5, 48'h0000_1234_0000, 48'h0000_1234_0000, 4'h8);
        commit();
        chk_txn(48'h0000_1234_0000, 1'b0, 1'b0, 1'b0, "R9 highest window denies");
        chk_txn(48'h0000_1234_0010, 1'b1, 1'b1, 1'b1, "R9 highest window grants");
        set_region(5, 48'h0000_1234_0000, 48'h0000_1234_0000, 4'h0);
        commit();
        chk_txn(48'h0000_1234_0000, 1'b1, 1'b0, 1'b1, "R9 disabled window skipped");
        set_region(3, 48'h0, 48'hFFFF_FFFF_FFFF, 4'h0);
        commit();
        chk_txn(48'h0000_1234_0000, 1'b0, 1'b0, 1'b1, "R9 falls to window 1");
        chk_txn(48'h0000_1234_0000, 1'b1, 1'b0, 1'b0, "R9 window 1 write bit clear");
        chk_txn(48'h8000_0000_0000, 1'b0, 1'b1, 1'b0, "R10 no enabled match");
    endtask

    task automatic t_cmd_seq();
        set_region(1, 48'h0000_1234_0000, 48'h0000_1235_0000, 4'h0);
        wr(13'h008, 32'd4);
        chk_txn(48'h0000_1234_0000, 1'b0, 1'b0, 1'b1, "R6 bare commit ignored");
        wr(13'h008, 32'd3);
        wr(13'h008, 32'd5);
        wr(13'h008, 32'd4);
        chk_txn(48'h0000_1234_0000, 1'b0, 1'b0, 1'b1, "R6 cancelled arm");
        commit();
        chk_txn(48'h0000_1234_0000, 1'b0, 1'b0, 1'b0, "R10 no window left");
        chk_rd(13'h000, 32'h3, "R5 status stays live");
    endtask

    task automatic t_idle();
        @(negedge clk);
        n_vec++;
        if (resp_valid !== 1'b0 || resp_allow !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: idle got valid=%0b allow=%0b expected 0/0", resp_valid, resp_allow);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_layout();
        t_commit();
        t_perms();
        t_overlap();
        t_cmd_seq();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule